// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block turns a stereo PCM serial stream into parallel samples. On every rising edge of the bit clock it takes one bit of serial data together with the current level of the word-select clock. A 3-bit mode code selects one of five framings: three right-aligned ones (16, 20 or 24 bits, with the word ending on the last slot before a word-select transition), a left-aligned 24-bit framing, and an I2S-compatible 24-bit framing whose MSB trails the word-select edge by one slot.

Each capture is widened to a 24-bit two's-complement value. When a right word has been captured after a left word, both output registers are loaded together and a frame-valid strobe is raised for one bit-clock cycle. A system with several serial data lines uses one instance per line, all sharing the bit and word-select clocks.

Top module: `audio_rx`

## Requirements
- R1: While reset is low, and on the first clock after it is released, `left` and `right` are zero and `valid` is low. The mode in force after reset is code 010, and it stays in force until the first falling word-select edge that follows reset.
- R2: Data and `lrck` are sampled on the rising edge of `bick`. Words arrive MSB first in two's complement. The first sample after reset only records the `lrck` level and never counts as a word-select edge.
- R3: Mode 000 takes the 16 bits that precede a word-select edge, with the last of them as the LSB, and sign-extends them to 24 bits. This works with as few as 16 slots per half-frame.
- R4: Mode 001 takes the 20 bits that precede a word-select edge and sign-extends them. This works with as few as 20 slots per half-frame.
- R5: Mode 100 takes the 24 bits that precede a word-select edge unchanged.
- R6: Mode 010 takes the bits in slots 0 to 23 of a half-frame, where slot 0 is the first sample after the edge. Later slots are ignored. Shorter words whose unused LSBs are zero pass through unchanged.
- R7: Mode 011 takes slots 1 to 24 after the edge, MSB first. With exactly 24 slots per half-frame, the LSB is the first sample after the next edge.
- R8: In modes 000, 001, 010 and 100 the left word is the one sent while `lrck` is high. In mode 011 the left word is the one sent while `lrck` is low.
- R9: `valid` pulses for one cycle when a right word is captured after a left word. Both outputs change only in that cycle. A right word with no left word before it is dropped.
- R10: Codes 101, 110 and 111 behave exactly like code 010.
- R11: The `fmt` input is copied into the active mode only at a falling `lrck` edge. The half-frame that begins at that edge uses the new mode.
- R12: In the right-aligned modes, slots earlier than the word have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bick | input | 1 | Bit clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrck | input | 1 | Word-select clock, one period per stereo frame |
| sdata | input | 1 | Serial audio data |
| fmt | input | 3 | Framing mode code |
| left | output | 24 | Last complete left sample, sign-extended |
| right | output | 24 | Last complete right sample, sign-extended |
| valid | output | 1 | One-cycle strobe when both samples update |

## Verification
The right-aligned modes are driven with ones in every slot before the word and with negative words. A design that takes the wrong window, or zero-fills instead of sign-extending, returns a visibly different value. Half-frames of exactly the minimum length are used: 16 and 20 slots for the short right-aligned modes, and 24 slots for I2S. In the 24-slot I2S case the LSB falls after the next edge, so a receiver that only captures inside the half-frame loses the right word or shifts it. A directed run sends a left-aligned left word right after reset while the mode input already asks for a right-aligned mode. A receiver that ignores the 010 reset default, or loads the mode at the wrong edge, then misreads that left word. Reserved codes are checked against left-aligned framing.

// File: rtl/audio_rx.sv
module audio_rx #(
  parameter int SLOT_W = 7
) (
  input  logic        bick,
  input  logic        rst_n,
  input  logic        lrck,
  input  logic        sdata,
  input  logic [2:0]  fmt,
  output logic [23:0] left,
  output logic [23:0] right,
  output logic        valid
);
  localparam int W = 24;
  localparam logic [2:0] FMT_RST = 3'b010;
  localparam logic [SLOT_W-1:0] SLOT_MAX = '1;
  localparam logic [SLOT_W-1:0] SLOT_MSB_END = SLOT_W'(W - 1);
  localparam logic [SLOT_W-1:0] SLOT_I2S_END = SLOT_W'(W);

  typedef enum logic [2:0] {M_R16, M_R20, M_R24, M_L24, M_I24} mode_t;

  logic [2:0]        fmt_q;
  logic              lrck_q, primed, synced, got_l;
  logic [W-1:0]      sr, hold_l;
  logic [SLOT_W-1:0] slot_q, cur_slot;
  mode_t             mode;
  logic              edge_s, cap, cap_left;
  logic [W-1:0]      word_now, right_word, cap_word;

  assign edge_s   = primed && (lrck != lrck_q);
  assign cur_slot = edge_s ? '0 : (slot_q == SLOT_MAX ? SLOT_MAX : slot_q + 1'b1);
  assign word_now = {sr[W-2:0], sdata};

  always_comb begin
    case (fmt_q)
      3'b000:  mode = M_R16;
      3'b001:  mode = M_R20;
      3'b011:  mode = M_I24;
      3'b100:  mode = M_R24;
      default: mode = M_L24;
    endcase
  end

  always_comb begin
    case (mode)
      M_R16:   right_word = {{(W-16){sr[15]}}, sr[15:0]};
      M_R20:   right_word = {{(W-20){sr[19]}}, sr[19:0]};
      default: right_word = sr;
    endcase
  end

  always_comb begin
    cap      = 1'b0;
    cap_left = 1'b0;
    cap_word = word_now;
    case (mode)
      M_L24: begin
        cap      = (cur_slot == SLOT_MSB_END);
        cap_left = lrck;
      end
      M_I24: begin
        if (edge_s) begin
          cap      = (slot_q == SLOT_MSB_END);
          cap_left = !lrck_q;
        end else begin
          cap      = (cur_slot == SLOT_I2S_END);
          cap_left = !lrck;
        end
      end
      default: begin
        cap      = edge_s && synced;
        cap_left = lrck_q;
        cap_word = right_word;
      end
    endcase
  end

  always_ff @(posedge bick or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q  <= FMT_RST;
      lrck_q <= 1'b0;
      primed <= 1'b0;
      synced <= 1'b0;
      slot_q <= SLOT_MAX;
      sr     <= '0;
      hold_l <= '0;
      got_l  <= 1'b0;
      left   <= '0;
      right  <= '0;
      valid  <= 1'b0;
    end else begin
      primed <= 1'b1;
      lrck_q <= lrck;
      sr     <= word_now;
      slot_q <= cur_slot;
      valid  <= 1'b0;
      if (edge_s) synced <= 1'b1;
      if (edge_s && !lrck) fmt_q <= fmt;
      if (cap) begin
        if (cap_left) begin
          hold_l <= cap_word;
          got_l  <= 1'b1;
        end else if (got_l) begin
          left  <= hold_l;
          right <= cap_word;
          valid <= 1'b1;
          got_l <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/audio_rx_chk.sv
module audio_rx_chk (
  input logic        bick,
  input logic        rst_n,
  input logic        lrck,
  input logic        valid,
  input logic [23:0] left,
  input logic [23:0] right,
  input logic [2:0]  fmt_q,
  input logic        got_l
);
  a_r1_reset_clears: assert property (@(posedge bick)
    !rst_n |=> (!valid && left == 24'd0 && right == 24'd0));

  a_r9_single_pulse: assert property (@(posedge bick) disable iff (!rst_n)
    valid |=> !valid);

  a_r9_outputs_hold: assert property (@(posedge bick) disable iff (!rst_n)
    !valid |-> ($stable(left) && $stable(right)));

  a_r9_left_before_right: assert property (@(posedge bick) disable iff (!rst_n)
    $rose(valid) |-> $past(got_l));

  a_r9_pair_consumed: assert property (@(posedge bick) disable iff (!rst_n)
    valid |-> !got_l);

  a_r11_mode_on_fall: assert property (@(posedge bick) disable iff (!rst_n)
    !$stable(fmt_q) |-> ($past(lrck) == 1'b0 && $past(lrck, 2) == 1'b1));
endmodule

bind audio_rx audio_rx_chk u_chk (
  .bick  (bick),
  .rst_n (rst_n),
  .lrck  (lrck),
  .valid (valid),
  .left  (left),
  .right (right),
  .fmt_q (fmt_q),
  .got_l (got_l)
);

// File: tb/audio_rx_test.sv
module audio_rx_test;
  localparam int CLK_P = 10;
  localparam int NVEC = 12;
  // fields: mode[58:56] slots per half[55:48] left[47:24] right[23:0]
  localparam logic [58:0] VEC [NVEC] = '{
    {3'b000, 8'd16, 24'h128001, 24'h007FFE},
    {3'b000, 8'd32, 24'h000123, 24'hABFFFF},
    {3'b001, 8'd20, 24'hF80001, 24'h07FFFF},
    {3'b001, 8'd32, 24'h123456, 24'hFABCDE},
    {3'b100, 8'd24, 24'h800000, 24'h7FFFFF},
    {3'b100, 8'd32, 24'hA5A5A5, 24'h5A5A5A},
    {3'b010, 8'd24, 24'hC0FFEE, 24'h012345},
    {3'b010, 8'd32, 24'h123400, 24'hFEDC00},
    {3'b011, 8'd24, 24'h89ABCD, 24'h765432},
    {3'b011, 8'd32, 24'h000001, 24'hFFFFFE},
    {3'b101, 8'd32, 24'h3C3C3C, 24'hC3C3C3},
    {3'b111, 8'd24, 24'h111111, 24'hEEEEEE}
  };

  logic bick = 1'b0;
  logic rst_n = 1'b0;
  logic lrck = 1'b0;
  logic sdata = 1'b0;
  logic [2:0] fmt = 3'b000;
  logic [23:0] left, right;
  logic valid;

  int nchk = 0, nerr = 0, nval = 0;
  logic [23:0] obs_l = '0, obs_r = '0;
  logic pend = 1'b0, pend_v = 1'b0;

  audio_rx uut (.bick(bick), .rst_n(rst_n), .lrck(lrck), .sdata(sdata),
                .fmt(fmt), .left(left), .right(right), .valid(valid));

  always #(CLK_P/2) bick = ~bick;

  always @(negedge bick) begin
    if (valid === 1'b1) begin
      if (nval == 0) begin
        obs_l = left;
        obs_r = right;
      end
      nval = nval + 1;
    end
  end

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    nchk++;
    nerr++;
    $display("FAIL R9 watchdog: actual hung expected done");
    finish_up();
  end

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int bmap(input logic [2:0] f);
    case (f)
      3'b000:  return 0;
      3'b001:  return 1;
      3'b011:  return 3;
      3'b100:  return 4;
      default: return 2;
    endcase
  endfunction

  function automatic logic [23:0] expv(input logic [2:0] f, input logic [23:0] w);
    case (bmap(f))
      0:       return {{8{w[15]}}, w[15:0]};
      1:       return {{4{w[19]}}, w[19:0]};
      default: return w;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] f);
    case (f)
      3'b000:  return "R3";
      3'b001:  return "R4";
      3'b100:  return "R5";
      3'b010:  return "R6";
      3'b011:  return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic send_slot(input logic lr, input logic d);
    @(negedge bick);
    lrck  = lr;
    sdata = d;
  endtask

  task automatic half(input logic [2:0] f, input int n, input logic lr, input logic [23:0] w);
    int m;
    m = bmap(f);
    for (int s = 0; s < n; s++) begin
      logic d;
      d = 1'b1;
      case (m)
        0: if (s >= n - 16) d = w[n-1-s];
        1: if (s >= n - 20) d = w[n-1-s];
        4: if (s >= n - 24) d = w[n-1-s];
        3: begin
          if (s == 0) d = pend_v ? pend : 1'b1;
          else if (s <= 24) d = w[24-s];
        end
        default: if (s < 24) d = w[23-s];
      endcase
      send_slot(lr, d);
    end
    if (m == 3 && n == 24) begin
      pend   = w[0];
      pend_v = 1'b1;
    end else begin
      pend_v = 1'b0;
    end
  endtask

  task automatic frame(input logic [2:0] f, input int n, input logic [23:0] l, input logic [23:0] r);
    if (bmap(f) == 3) begin
      half(f, n, 1'b0, l);
      half(f, n, 1'b1, r);
    end else begin
      half(f, n, 1'b1, l);
      half(f, n, 1'b0, r);
    end
  endtask

  task automatic do_reset();
    @(negedge bick);
    rst_n  = 1'b0;
    lrck   = 1'b0;
    sdata  = 1'b0;
    pend_v = 1'b0;
    repeat (2) @(negedge bick);
    rst_n = 1'b1;
    nval  = 0;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge bick);
    chk("R1 left at reset", left, 24'h0);
    chk("R1 right at reset", right, 24'h0);
    chk("R1 valid at reset", {23'b0, valid}, 24'h0);

    // table of modes (R2 R8 R12 exercised throughout)
    for (int i = 0; i < NVEC; i++) begin
      logic [2:0] f;
      int n;
      logic [23:0] l, r;
      f = VEC[i][58:56];
      n = int'(VEC[i][55:48]);
      l = VEC[i][47:24];
      r = VEC[i][23:0];
      do_reset();
      fmt = f;
      if (bmap(f) == 3) begin
        repeat (4) send_slot(1'b0, 1'b0);
        repeat (4) send_slot(1'b1, 1'b0);
      end else begin
        repeat (4) send_slot(1'b1, 1'b0);
        repeat (4) send_slot(1'b0, 1'b0);
      end
      frame(f, n, l, r);
      frame(f, n, 24'h0, 24'h0);
      repeat (3) @(negedge bick);
      chk({req_of(f), " R9 frame strobe seen"}, {23'b0, nval > 0}, 24'h1);
      chk({req_of(f), " R2 R8 R12 left"}, obs_l, expv(f, l));
      chk({req_of(f), " R2 R8 R12 right"}, obs_r, expv(f, r));
    end

    // R1 R11: default mode 010 rules until the first falling lrck edge
    do_reset();
    fmt = 3'b100;
    repeat (4) send_slot(1'b0, 1'b0);
    half(3'b010, 32, 1'b1, 24'h9ABCDE);
    half(3'b100, 32, 1'b0, 24'h13579B);
    half(3'b100, 32, 1'b1, 24'h000000);
    repeat (3) @(negedge bick);
    chk("R1 R11 left under default mode", obs_l, 24'h9ABCDE);
    chk("R11 right under loaded mode", obs_r, 24'h13579B);

    // R1: reset in mid-stream clears the outputs
    @(negedge bick);
    rst_n = 1'b0;
    @(negedge bick);
    chk("R1 left after mid-stream reset", left, 24'h0);
    chk("R1 right after mid-stream reset", right, 24'h0);
    chk("R1 valid after mid-stream reset", {23'b0, valid}, 24'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge bick);

    finish_up();
  end
endmodule